// File: doc/BRIEF.md
# Oversampling Serial Receive Path with Error Flags

This block is the receive half of an asynchronous serial port. It watches the incoming serial line on a sub-bit tick that runs at sixteen times the bit rate. A falling edge is taken as a possible start bit and is confirmed half a bit later. Each bit after that is sampled once, in the middle of its bit period. The frame format is set on static configuration inputs: five to eight data bits, parity enabled or not, and odd or even parity.

Each finished word is written into a small receive queue. The data byte is stored together with its parity-error and framing-error bits. The host reads the oldest word from a byte-wide holding port and removes it with a one-cycle pop strobe. Line-status outputs show the error bits of the word at the head of the queue. They also show a sticky overrun flag, which is set when a word arrives while the queue is full and is cleared by a status-read strobe. A data-ready flag and the queue occupancy are also provided. The generator of the sub-bit tick is outside this block.

Top module: `serial_rx_path`

## Requirements
- R1: After a synchronous reset, data_ready is 0, rx_count is 0, and err_parity, err_frame and err_overrun are all 0.
- R2: A low level on rx_line is confirmed as a start bit only if the line is still low at the 8th sub-tick after detection. If the line is high by then, nothing is received and the receiver returns to hunting for a start bit.
- R3: After a confirmed start, a bit is sampled every 16 sub-ticks. Data arrives least significant bit first. The number of data bits is 5 + cfg_len (cfg_len 00=5, 01=6, 10=7, 11=8), and the unused upper bits of rd_byte read as 0.
- R4: When cfg_par_on is 1, one parity bit follows the data. With cfg_par_even=1 the data bits and the parity bit together hold an even number of ones; with cfg_par_even=0 they hold an odd number. A mismatch sets the parity-error bit stored with that word.
- R5: A stop bit sampled as 0 sets the framing-error bit stored with that word. After such a word, the receiver waits for the line to return high before it hunts for the next start bit.
- R6: The queue holds up to FIFO_DEPTH words (16 by default) in arrival order. rx_count reports the occupancy. A rd_pop pulse removes the head word, and a pop while the queue is empty has no effect.
- R7: A word that completes while the queue is full is discarded and sets err_overrun. err_overrun stays set until an lsr_read pulse clears it.
- R8: err_parity and err_frame show the error bits of the word currently at the head of the queue, and read 0 when the queue is empty.
- R9: data_ready is 1 exactly when rx_count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sub-bit tick enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par_on | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rd_pop | input | 1 | Remove the head word |
| lsr_read | input | 1 | Status read strobe; clears err_overrun |
| rd_byte | output | 8 | Data byte of the head word |
| data_ready | output | 1 | Queue not empty |
| rx_count | output | CNT_W | Number of queued words |
| err_parity | output | 1 | Parity error of the head word |
| err_frame | output | 1 | Framing error of the head word |
| err_overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default values: a 16-entry queue and a two-stage input synchronizer. The sub-tick is generated every fourth clock, so one bit lasts 64 clocks. This keeps a frame short enough that sixteen words plus one extra can be sent to fill the queue completely and reach the overrun case. The table of frames covers every data length from five to eight bits, both parity senses, injected parity and stop-bit faults, and a short low glitch on an idle line.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_HUNT,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_WAIT
  } rx_state_e;

  typedef struct packed {
    logic              fe;
    logic              pe;
    logic [BYTE_W-1:0] data;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);
endpackage

// File: rtl/srx_sync.sv
`timescale 1ns/1ps
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
`timescale 1ns/1ps
module srx_deframer
  import srx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rx,
  input  logic [1:0] cfg_len,
  input  logic     cfg_par_on,
  input  logic     cfg_par_even,
  output logic     word_valid,
  output rx_word_t word
);
  localparam logic [3:0] HALF_LAST = 4'd7;
  localparam logic [3:0] FULL_LAST = 4'd15;

  rx_state_e         state;
  logic [3:0]        sub_cnt;
  logic [2:0]        bit_idx;
  logic [BYTE_W-1:0] shreg;
  logic              par_bad;
  logic [2:0]        last_idx;

  assign last_idx = {1'b1, cfg_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_HUNT;
      sub_cnt    <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      par_bad    <= 1'b0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      case (state)
        S_HUNT: begin
          sub_cnt <= '0;
          if (tick && !rx) state <= S_START;
        end
        S_START: if (tick) begin
          if (sub_cnt == HALF_LAST) begin
            sub_cnt <= '0;
            if (rx) begin
              state <= S_HUNT;
            end else begin
              state   <= S_DATA;
              bit_idx <= '0;
              shreg   <= '0;
              par_bad <= 1'b0;
            end
          end else begin
            sub_cnt <= sub_cnt + 4'd1;
          end
        end
        S_DATA: if (tick) begin
          if (sub_cnt == FULL_LAST) begin
            sub_cnt        <= '0;
            shreg[bit_idx] <= rx;
            if (bit_idx == last_idx) state <= cfg_par_on ? S_PAR : S_STOP;
            else                     bit_idx <= bit_idx + 3'd1;
          end else begin
            sub_cnt <= sub_cnt + 4'd1;
          end
        end
        S_PAR: if (tick) begin
          if (sub_cnt == FULL_LAST) begin
            sub_cnt <= '0;
            par_bad <= (^shreg) ^ rx ^ ~cfg_par_even;
            state   <= S_STOP;
          end else begin
            sub_cnt <= sub_cnt + 4'd1;
          end
        end
        S_STOP: if (tick) begin
          if (sub_cnt == FULL_LAST) begin
            sub_cnt    <= '0;
            word_valid <= 1'b1;
            word.fe    <= ~rx;
            word.pe    <= par_bad;
            word.data  <= shreg;
            state      <= rx ? S_HUNT : S_WAIT;
          end else begin
            sub_cnt <= sub_cnt + 4'd1;
          end
        end
        S_WAIT: if (rx) state <= S_HUNT;
        default: state <= S_HUNT;
      endcase
    end
  end

  // R2: a start that is high again at the half-bit check is dropped
  p_glitch_reject_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_START && tick && sub_cnt == HALF_LAST && rx) |=> (state == S_HUNT && !word_valid));

  // R5: a low stop bit flags the word and parks the receiver until idle
  p_stop_low_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_STOP && tick && sub_cnt == FULL_LAST && !rx) |=> (state == S_WAIT && word_valid && word.fe));
endmodule

// File: rtl/srx_fifo.sv
`timescale 1ns/1ps
module srx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] head,
  output logic [CW-1:0] count,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      if (do_wr && !do_rd) begin
        count <= count + 1'b1;
        empty <= 1'b0;
        full  <= (count == CW'(DEPTH - 1));
      end else if (do_rd && !do_wr) begin
        count <= count - 1'b1;
        full  <= 1'b0;
        empty <= (count == CW'(1));
      end
    end
  end

  assign head = mem[rptr];

  // R6: occupancy never exceeds the depth
  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R7: a write into a full queue without a pop leaves occupancy unchanged
  p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> $stable(count));
endmodule

// File: rtl/serial_rx_path.sv
`timescale 1ns/1ps
module serial_rx_path
  import srx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick16,
  input  logic             rx_line,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_on,
  input  logic             cfg_par_even,
  input  logic             rd_pop,
  input  logic             lsr_read,
  output logic [BYTE_W-1:0] rd_byte,
  output logic             data_ready,
  output logic [CNT_W-1:0] rx_count,
  output logic             err_parity,
  output logic             err_frame,
  output logic             err_overrun
);
  logic     rx_s;
  logic     word_valid;
  rx_word_t word;
  rx_word_t head;
  logic     q_full, q_empty;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(rx_line), .d_out(rx_s)
  );

  srx_deframer u_deframer (
    .clk(clk), .rst(rst), .tick(tick16), .rx(rx_s),
    .cfg_len(cfg_len), .cfg_par_on(cfg_par_on), .cfg_par_even(cfg_par_even),
    .word_valid(word_valid), .word(word)
  );

  srx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(word_valid), .wr_data(word),
    .rd_en(rd_pop), .head(head),
    .count(rx_count), .full(q_full), .empty(q_empty)
  );

  always_ff @(posedge clk) begin
    if (rst)                     err_overrun <= 1'b0;
    else if (word_valid && q_full) err_overrun <= 1'b1;
    else if (lsr_read)           err_overrun <= 1'b0;
  end

  assign data_ready = ~q_empty;
  assign rd_byte    = q_empty ? '0 : head.data;
  assign err_parity = ~q_empty & head.pe;
  assign err_frame  = ~q_empty & head.fe;

  // R9: ready flag and occupancy agree
  p_ready_count_r9: assert property (@(posedge clk) disable iff (rst)
    data_ready == (rx_count != '0));

  // R7: a word landing on a full queue raises overrun
  p_overrun_set_r7: assert property (@(posedge clk) disable iff (rst)
    (word_valid && q_full) |=> err_overrun);
endmodule

// File: tb/tb_serial_rx_path.sv
`timescale 1ns/1ps
module tb_serial_rx_path;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick16;
  logic       rx_line;
  logic [1:0] cfg_len;
  logic       cfg_par_on, cfg_par_even;
  logic       rd_pop, lsr_read;
  logic [7:0] rd_byte;
  logic       data_ready;
  logic [4:0] rx_count;
  logic       err_parity, err_frame, err_overrun;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;
  logic [1:0] tcnt;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) tcnt <= '0;
    else     tcnt <= tcnt + 2'd1;
  end
  assign tick16 = (tcnt == 2'd3);

  serial_rx_path dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_par_on(cfg_par_on), .cfg_par_even(cfg_par_even),
    .rd_pop(rd_pop), .lsr_read(lsr_read), .rd_byte(rd_byte),
    .data_ready(data_ready), .rx_count(rx_count),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  // {data[7:0], len[1:0], par_on, par_even, inject_bad_parity, inject_bad_stop}
  localparam logic [13:0] VEC [7] = '{
    {8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h5A, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hFF, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h96, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h42, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h81, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk) rx_line = b;
    repeat (63) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] len, input logic pon,
                            input logic peven, input logic badp, input logic bads);
    logic [7:0] dm;
    logic       p;
    dm = d & (8'hFF >> (3 - len));
    cfg_len = len; cfg_par_on = pon; cfg_par_even = peven;
    drive_bit(1'b0);
    for (int i = 0; i < 5 + int'(len); i++) drive_bit(d[i]);
    if (pon) begin
      p = (^dm) ^ ~peven;
      drive_bit(badp ? ~p : p);
    end
    drive_bit(bads ? 1'b0 : 1'b1);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic pop();
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_d;
    rst = 1'b1; rx_line = 1'b1; rd_pop = 1'b0; lsr_read = 1'b0;
    cfg_len = 2'b11; cfg_par_on = 1'b0; cfg_par_even = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(!data_ready, "R1 data_ready", data_ready, 0);
    check(rx_count == 0, "R1 rx_count", rx_count, 0);
    check(!err_parity && !err_frame && !err_overrun, "R1 flags",
          {err_parity, err_frame, err_overrun}, 0);

    // table of frames: R3 R4 R5 R9
    foreach (VEC[k]) begin
      send_frame(VEC[k][13:6], VEC[k][5:4], VEC[k][3], VEC[k][2], VEC[k][1], VEC[k][0]);
      exp_d = VEC[k][13:6] & (8'hFF >> (3 - VEC[k][5:4]));
      check(rx_count == 1 && data_ready, "R9 one word queued", rx_count, 1);
      check(rd_byte == exp_d, "R3 data byte", rd_byte, exp_d);
      check(err_parity == (VEC[k][1] & VEC[k][3]), "R4 parity flag", err_parity,
            VEC[k][1] & VEC[k][3]);
      check(err_frame == VEC[k][0], "R5 framing flag", err_frame, VEC[k][0]);
      pop();
      check(rx_count == 0 && !data_ready, "R9 empty after pop", rx_count, 0);
    end

    // R2 short glitches on idle line
    cfg_len = 2'b11; cfg_par_on = 1'b0;
    @(negedge clk) rx_line = 1'b0;
    repeat (8) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    check(rx_count == 0, "R2 8-clock glitch rejected", rx_count, 0);
    rx_line = 1'b0;
    repeat (20) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    check(rx_count == 0, "R2 20-clock glitch rejected", rx_count, 0);
    send_frame(8'h6E, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    check(rx_count == 1 && rd_byte == 8'h6E, "R2 frame after glitch", rd_byte, 8'h6E);
    pop();

    // R8 flags follow head
    send_frame(8'h11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0);
    send_frame(8'h22, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    check(rx_count == 2 && err_parity, "R8 head carries parity error", err_parity, 1);
    pop();
    check(!err_parity && rd_byte == 8'h22, "R8 clean head after pop", err_parity, 0);
    pop();

    // R6 R7 fill and overrun
    for (int i = 0; i < 16; i++) send_frame(8'(i + 1), 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    check(rx_count == 16, "R6 full count", rx_count, 16);
    check(!err_overrun, "R7 no overrun at exactly full", err_overrun, 0);
    send_frame(8'hEE, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    check(rx_count == 16, "R7 extra word discarded", rx_count, 16);
    check(err_overrun, "R7 overrun set", err_overrun, 1);
    @(negedge clk) lsr_read = 1'b1;
    @(negedge clk) lsr_read = 1'b0;
    check(!err_overrun, "R7 overrun cleared by status read", err_overrun, 0);
    for (int i = 0; i < 16; i++) begin
      check(rd_byte == 8'(i + 1), "R6 arrival order", rd_byte, i + 1);
      pop();
    end
    check(rx_count == 0 && !data_ready, "R6 drained", rx_count, 0);
    pop();
    check(rx_count == 0, "R6 pop on empty ignored", rx_count, 0);
    check(!err_parity && !err_frame, "R8 flags zero when empty", {err_parity, err_frame}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule